// File: doc/BRIEF.md
# SPI Burst Register Access Target for a Timekeeping Register File

This block is the serial target side of a clock/calendar register file that also carries a 256-byte scratch memory. A host lowers chip select and sends one command byte. Bit 7 of that byte picks the direction: 1 means write and 0 means read. Bits 6:0 give the starting register. Every later byte reads or writes one register, and the register pointer advances by itself after each byte for as long as chip select stays low. Reads and writes each loop over their own window. A read loops from 13h back to 00h. A write loops from 93h back to 80h, so write addresses are the read addresses with bit 7 set.

The seven time bytes at 00h-06h come from a parallel live-time bus that the clock counters drive. Reads see a user copy of these bytes. The user copy is captured when chip select falls and again whenever a read pointer loops from 13h to 00h. It is not refreshed at any other time. Writes to the time bytes leave the block as one-cycle load strobes for the counters. Registers 07h-13h are held locally.

Register 18h (98h for writes) is the scratch-memory pointer. Register 19h (99h for writes) is the scratch-memory data port. A burst that reaches the data port stays on it, and the pointer advances modulo 256 after every byte. All SPI pins are sampled by the system clock, so the serial clock must run at least about eight times slower than that clock.

Top module: `spi_rtc_slave`

State machine: `ST_IDLE` (chip select high) goes to `ST_ADDR` when chip select falls. `ST_ADDR` goes to `ST_READ` or `ST_WRITE` on the eighth sampled bit, chosen by command bit 7. Any state goes back to `ST_IDLE` as soon as chip select is high.

## Requirements
- R1: SPI mode 0 is used by default, MSB first. MOSI is sampled on the rising serial-clock edge, and MISO changes after the falling edge. The first byte after chip select falls is the command byte, with bit 7 = 1 for write and bit 7 = 0 for read.
- R2: `spi_miso_oe` is 0 while chip select is high and throughout the command byte. `spi_miso` is 0 whenever `spi_miso_oe` is 0.
- R3: A one-byte read returns the register at the command address: the user time copy for 00h-06h, or the stored value for 07h-13h.
- R4: A one-byte write to 87h-93h stores the byte into register 07h-13h.
- R5: In a read burst the pointer advances by one after each data byte and goes from 13h to 00h.
- R6: In a write burst the pointer advances by one after each data byte and goes from 93h to 80h.
- R7: The user time copy is loaded from `live_time` (byte i at bits 8i+7:8i) when chip select falls. Later changes of `live_time` are not visible in that burst until a refresh.
- R8: When a read pointer goes from 13h to 00h, the user time copy is reloaded from `live_time` before byte 00h is sent.
- R9: A data byte written to 80h-86h raises `tm_wr_en` for exactly one clock, with `tm_wr_addr` = 0-6 and `tm_wr_data` = the byte.
- R10: A write to 98h loads the 8-bit scratch pointer, and a read of 18h returns it. The pointer then steps to 19h/99h as usual.
- R11: A read of 19h or a write to 99h accesses the scratch memory at the pointer. The register pointer stays on 19h/99h for the rest of the burst, and the scratch pointer steps by one (mod 256) after each byte.
- R12: After reset, `spi_miso_oe`, `spi_miso` and `tm_wr_en` are 0, and registers 07h-13h read as 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Drive enable for the MISO pad (0 = high impedance) |
| live_time | input | 8*N_TIME | Live time bytes from the counters |
| tm_wr_en | output | 1 | One-cycle strobe that loads a counter byte |
| tm_wr_addr | output | 7 | Time byte index 0..N_TIME-1 |
| tm_wr_data | output | 8 | Byte to load into the counter |

## Verification
A pointer that steps wrongly or loops at the wrong place shows up as a wrong MISO byte at the very next data byte of a burst. A bad write pointer shows up on the next read-back of the target register or in a misdirected `tm_wr_addr` strobe. A stale or early user time copy appears in the first time byte sent after chip select falls or after the 13h-to-00h loop. A scratch pointer that fails to stick or step returns the wrong data within one byte of a burst on 19h and the wrong value on the next read of 18h. A drive-enable fault is visible within a few system clocks of a chip-select change.

// File: rtl/spi_rtc_pkg.sv
package spi_rtc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_READ,
        ST_WRITE
    } link_state_e;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
    parameter int MODE = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    output logic cs_act,
    output logic cs_fall_p,
    output logic samp_p,
    output logic shift_p,
    output logic mosi_s
);
    localparam logic IDLE_CLK   = (MODE >= 2);
    localparam logic SAMPLE_UP  = (MODE == 0) || (MODE == 3);

    logic [2:0] cs_sh;
    logic [2:0] ck_sh;
    logic [1:0] di_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_sh <= 3'b111;
            ck_sh <= {3{IDLE_CLK}};
            di_sh <= 2'b00;
        end else begin
            cs_sh <= {cs_sh[1:0], cs_n};
            ck_sh <= {ck_sh[1:0], sclk};
            di_sh <= {di_sh[0], mosi};
        end
    end

    logic rise, fall;
    assign rise      = ck_sh[1] & ~ck_sh[2];
    assign fall      = ~ck_sh[1] & ck_sh[2];
    assign cs_act    = ~cs_sh[1];
    assign cs_fall_p = ~cs_sh[1] & cs_sh[2];
    assign mosi_s    = di_sh[1];

    generate
        if (SAMPLE_UP) begin : g_up
            assign samp_p  = cs_act & rise;
            assign shift_p = cs_act & fall;
        end else begin : g_dn
            assign samp_p  = cs_act & fall;
            assign shift_p = cs_act & rise;
        end
    endgenerate
endmodule

// File: rtl/rtc_reg_store.sv
module rtc_reg_store #(
    parameter int N_TIME  = 7,
    parameter int LAST    = 'h13,
    parameter int SADR    = 'h18,
    parameter int SDAT    = 'h19,
    parameter int SRAM_AW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [8*N_TIME-1:0]   live_time,
    input  logic                  snap_ld,
    input  logic                  wr_en,
    input  logic [6:0]            wr_addr,
    input  logic [7:0]            wr_data,
    input  logic                  sdat_step,
    input  logic [6:0]            rd_addr,
    output logic [7:0]            rd_data,
    output logic [SRAM_AW-1:0]    sram_ptr
);
    localparam int DEPTH = 1 << SRAM_AW;

    logic [7:0] snap_q [N_TIME];
    logic [7:0] gen_q  [N_TIME:LAST];
    logic [7:0] mem    [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_TIME; i++) snap_q[i] <= '0;
        end else if (snap_ld) begin
            for (int i = 0; i < N_TIME; i++) snap_q[i] <= live_time[8*i +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = N_TIME; i <= LAST; i++) gen_q[i] <= '0;
        end else if (wr_en) begin
            for (int i = N_TIME; i <= LAST; i++)
                if (wr_addr == 7'(i)) gen_q[i] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sram_ptr <= '0;
        else if (wr_en && wr_addr == 7'(SADR))
            sram_ptr <= wr_data[SRAM_AW-1:0];
        else if (sdat_step)
            sram_ptr <= sram_ptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en && wr_addr == 7'(SDAT)) mem[sram_ptr] <= wr_data;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_TIME; i++)
            if (rd_addr == 7'(i)) rd_data = snap_q[i];
        for (int i = N_TIME; i <= LAST; i++)
            if (rd_addr == 7'(i)) rd_data = gen_q[i];
        if (rd_addr == 7'(SADR)) rd_data = 8'(sram_ptr);
        if (rd_addr == 7'(SDAT)) rd_data = mem[sram_ptr];
    end
endmodule

// File: rtl/spi_rtc_slave.sv
module spi_rtc_slave
    import spi_rtc_pkg::*;
#(
    parameter int MODE    = 0,
    parameter int N_TIME  = 7,
    parameter int LAST    = 'h13,
    parameter int SADR    = 'h18,
    parameter int SDAT    = 'h19,
    parameter int SRAM_AW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                spi_cs_n,
    input  logic                spi_sclk,
    input  logic                spi_mosi,
    output logic                spi_miso,
    output logic                spi_miso_oe,
    input  logic [8*N_TIME-1:0] live_time,
    output logic                tm_wr_en,
    output logic [6:0]          tm_wr_addr,
    output logic [7:0]          tm_wr_data
);
    logic cs_act, cs_fall_p, samp_p, shift_p, mosi_s;

    spi_edge_sync #(.MODE(MODE)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk),
        .mosi(spi_mosi), .cs_act(cs_act), .cs_fall_p(cs_fall_p),
        .samp_p(samp_p), .shift_p(shift_p), .mosi_s(mosi_s)
    );

    link_state_e state_q, state_d;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sh;
    logic [7:0] tx_sh;
    logic [6:0] ptr_q;
    logic       oe_q;
    logic [7:0] rx_byte;
    logic       byte_done, addr_done, data_done, on_sdat, at_last;
    logic       wr_stb, snap_ld, sdat_step, sadr_load;
    logic [7:0] rd_data;
    logic [SRAM_AW-1:0] sram_ptr;

    assign rx_byte   = {rx_sh, mosi_s};
    assign byte_done = samp_p && (bit_cnt == 3'd7);
    assign addr_done = byte_done && (state_q == ST_ADDR);
    assign data_done = byte_done && (state_q == ST_READ || state_q == ST_WRITE);
    assign on_sdat   = (ptr_q == 7'(SDAT));
    assign at_last   = (ptr_q == 7'(LAST));
    assign wr_stb    = data_done && (state_q == ST_WRITE);
    assign snap_ld   = cs_fall_p || (data_done && state_q == ST_READ && at_last);
    assign sdat_step = data_done && on_sdat;
    assign sadr_load = wr_stb && (ptr_q == 7'(SADR));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cs_fall_p) state_d = ST_ADDR;
            ST_ADDR:  if (!cs_act) state_d = ST_IDLE;
                      else if (byte_done) state_d = rx_byte[7] ? ST_WRITE : ST_READ;
            ST_READ:  if (!cs_act) state_d = ST_IDLE;
            ST_WRITE: if (!cs_act) state_d = ST_IDLE;
        endcase
    end

    // serial datapath and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            ptr_q   <= '0;
        end else begin
            if (!cs_act) begin
                bit_cnt <= '0;
            end else if (samp_p) begin
                bit_cnt <= bit_cnt + 3'd1;
                rx_sh   <= {rx_sh[5:0], mosi_s};
            end
            if (shift_p && state_q == ST_READ)
                tx_sh <= (bit_cnt == 3'd0) ? rd_data : {tx_sh[6:0], 1'b0};
            if (addr_done)
                ptr_q <= rx_byte[6:0];
            else if (data_done && !on_sdat)
                ptr_q <= at_last ? 7'd0 : ptr_q + 7'd1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q       <= 1'b0;
            tm_wr_en   <= 1'b0;
            tm_wr_addr <= '0;
            tm_wr_data <= '0;
        end else begin
            if (!cs_act || state_q != ST_READ) oe_q <= 1'b0;
            else if (shift_p)                  oe_q <= 1'b1;
            tm_wr_en <= wr_stb && (ptr_q < 7'(N_TIME));
            if (wr_stb) begin
                tm_wr_addr <= ptr_q;
                tm_wr_data <= rx_byte;
            end
        end
    end

    assign spi_miso_oe = oe_q;
    assign spi_miso    = oe_q & tx_sh[7];

    rtc_reg_store #(
        .N_TIME(N_TIME), .LAST(LAST), .SADR(SADR), .SDAT(SDAT), .SRAM_AW(SRAM_AW)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .live_time(live_time), .snap_ld(snap_ld),
        .wr_en(wr_stb), .wr_addr(ptr_q), .wr_data(rx_byte),
        .sdat_step(sdat_step), .rd_addr(ptr_q), .rd_data(rd_data),
        .sram_ptr(sram_ptr)
    );
endmodule

// File: rtl/spi_rtc_slave_chk.sv
module spi_rtc_slave_chk #(
    parameter int N_TIME  = 7,
    parameter int SRAM_AW = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               spi_cs_n,
    input logic               spi_miso,
    input logic               spi_miso_oe,
    input logic               tm_wr_en,
    input logic [6:0]         tm_wr_addr,
    input logic [SRAM_AW-1:0] sram_ptr,
    input logic               sadr_load
);
    // R2
    miso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)
            && $past(spi_cs_n, 4) |-> !spi_miso_oe);

    // R2
    miso_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_miso_oe |-> !spi_miso);

    // R9
    tm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tm_wr_en |=> !tm_wr_en);

    // R9
    tm_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tm_wr_en |-> tm_wr_addr < 7'(N_TIME));

    // R11
    sram_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sadr_load) && sram_ptr != $past(sram_ptr)
            |-> sram_ptr == $past(sram_ptr) + 1'b1);
endmodule

bind spi_rtc_slave spi_rtc_slave_chk #(.N_TIME(N_TIME), .SRAM_AW(SRAM_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
    .spi_miso_oe(spi_miso_oe), .tm_wr_en(tm_wr_en), .tm_wr_addr(tm_wr_addr),
    .sram_ptr(sram_ptr), .sadr_load(sadr_load)
);

// File: tb/spi_rtc_slave_test.sv
module spi_rtc_slave_test;
    localparam int NT = 7;
    localparam logic [55:0] LIVE0 = 56'h26_12_31_05_23_59_40;
    localparam logic [55:0] LIVE1 = 56'h27_01_01_06_00_00_01;
    localparam logic [55:0] LIVE2 = 56'h27_01_01_06_00_00_17;

    typedef struct packed {
        logic       wr;
        logic [7:0] addr;
        logic [7:0] data;
        logic [7:0] req;
    } vec_t;

    // single-byte vectors: R4 writes, R3 reads, R10 pointer, R7 snapshot
    localparam vec_t VECS [8] = '{
        '{1'b1, 8'h87, 8'h5A, 8'd4},
        '{1'b0, 8'h07, 8'h5A, 8'd3},
        '{1'b1, 8'h93, 8'hC3, 8'd4},
        '{1'b0, 8'h13, 8'hC3, 8'd3},
        '{1'b1, 8'h98, 8'h10, 8'd10},
        '{1'b0, 8'h18, 8'h10, 8'd10},
        '{1'b0, 8'h00, LIVE0[7:0], 8'd7},
        '{1'b0, 8'h06, LIVE0[55:48], 8'd3}
    };

    logic clk = 0, rst_n = 0;
    logic spi_cs_n = 1, spi_sclk = 0, spi_mosi = 0;
    logic spi_miso, spi_miso_oe, tm_wr_en;
    logic [6:0] tm_wr_addr;
    logic [7:0] tm_wr_data;
    logic [55:0] live_time = LIVE0;

    int n_chk = 0, n_bad = 0;
    int tm_cnt = 0;
    logic [6:0] tm_la;
    logic [7:0] tm_ld;
    logic [7:0] tx_buf [16];
    logic [7:0] rx_buf [16];
    int swap_at = -1;
    logic [55:0] live_next;
    logic addr_phase = 0, oe_addr_bad = 0;
    logic done = 0;

    always #4 clk = ~clk;

    spi_rtc_slave uut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .live_time(live_time), .tm_wr_en(tm_wr_en), .tm_wr_addr(tm_wr_addr),
        .tm_wr_data(tm_wr_data)
    );

    always @(negedge clk) if (tm_wr_en) begin
        tm_cnt++;
        tm_la = tm_wr_addr;
        tm_ld = tm_wr_data;
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic spi_bit(input logic b, output logic r);
        spi_mosi = b;
        repeat (8) @(negedge clk);
        r = spi_miso;
        if (addr_phase && spi_miso_oe) oe_addr_bad = 1;
        spi_sclk = 1;
        repeat (8) @(negedge clk);
        spi_sclk = 0;
    endtask

    task automatic spi_byte(input logic [7:0] t, output logic [7:0] r);
        for (int b = 7; b >= 0; b--) spi_bit(t[b], r[b]);
    endtask

    task automatic spi_txn(input logic [7:0] addr, input int n);
        logic [7:0] dummy;
        @(negedge clk);
        spi_cs_n = 0;
        repeat (8) @(negedge clk);
        addr_phase = 1;
        spi_byte(addr, dummy);
        addr_phase = 0;
        for (int i = 0; i < n; i++) begin
            if (i == swap_at) live_time = live_next;
            spi_byte(tx_buf[i], rx_buf[i]);
        end
        repeat (8) @(negedge clk);
        spi_cs_n = 1;
        repeat (16) @(negedge clk);
        swap_at = -1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (4) @(negedge clk);
        chk("R12 oe", spi_miso_oe, 0);
        chk("R12 miso", spi_miso, 0);
        chk("R12 tm_wr_en", tm_wr_en, 0);
        tx_buf[0] = 8'h00;
        spi_txn(8'h0C, 1);
        chk("R12 reg 0Ch", rx_buf[0], 8'h00);

        // vector table, R1 framing on every entry
        for (int v = 0; v < 8; v++) begin
            tx_buf[0] = VECS[v].data;
            spi_txn(VECS[v].addr, 1);
            if (!VECS[v].wr) begin
                n_chk++;
                if (rx_buf[0] !== VECS[v].data) begin
                    n_bad++;
                    $display("FAIL R%0d addr=%0h got=%0h exp=%0h",
                             VECS[v].req, VECS[v].addr, rx_buf[0], VECS[v].data);
                end
            end
        end
        chk("R2 oe during address byte", oe_addr_bad, 0);
        chk("R2 oe idle", spi_miso_oe, 0);

        // R6 write burst 91h..93h then 80h, R9 time strobe
        base = tm_cnt;
        tx_buf[0] = 8'h11; tx_buf[1] = 8'h22; tx_buf[2] = 8'h33; tx_buf[3] = 8'h44;
        spi_txn(8'h91, 4);
        chk("R9 one strobe", tm_cnt - base, 1);
        chk("R6 wrap to 80h addr", tm_la, 0);
        chk("R9 strobe data", tm_ld, 8'h44);

        // R5/R8 read burst crossing 13h->00h with live change mid-burst
        live_next = LIVE1;
        swap_at = 2;
        for (int i = 0; i < 4; i++) tx_buf[i] = 8'h00;
        spi_txn(8'h11, 4);
        chk("R5 reg 11h", rx_buf[0], 8'h11);
        chk("R5 reg 12h", rx_buf[1], 8'h22);
        chk("R5 reg 13h", rx_buf[2], 8'h33);
        chk("R8 refreshed 00h", rx_buf[3], LIVE1[7:0]);

        // R7 snapshot held through burst
        live_next = LIVE2;
        swap_at = 1;
        spi_txn(8'h05, 3);
        chk("R7 byte 05h", rx_buf[0], LIVE1[47:40]);
        chk("R7 byte 06h held", rx_buf[1], LIVE1[55:48]);
        chk("R5 step to 07h", rx_buf[2], 8'h5A);
        spi_txn(8'h00, 1);
        chk("R7 new snapshot", rx_buf[0], LIVE2[7:0]);

        // R11 scratch burst with pointer wrap
        tx_buf[0] = 8'hFE; tx_buf[1] = 8'hA1; tx_buf[2] = 8'hA2;
        tx_buf[3] = 8'hA3; tx_buf[4] = 8'hA4;
        spi_txn(8'h98, 5);
        spi_txn(8'h18, 1);
        chk("R11 pointer mod 256", rx_buf[0], 8'h02);
        tx_buf[0] = 8'hFE;
        spi_txn(8'h98, 1);
        for (int i = 0; i < 5; i++) tx_buf[i] = 8'h00;
        spi_txn(8'h18, 5);
        chk("R10 pointer read", rx_buf[0], 8'hFE);
        chk("R11 data FEh", rx_buf[1], 8'hA1);
        chk("R11 data FFh", rx_buf[2], 8'hA2);
        chk("R11 data 00h", rx_buf[3], 8'hA3);
        chk("R11 data 01h", rx_buf[4], 8'hA4);
        chk("R2 oe after burst", spi_miso_oe, 0);
        chk("R2 oe in address bytes", oe_addr_bad, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule